// File: doc/BRIEF.md
# Self-Correcting Triple-Redundant Configuration Register Bank

This block holds a set of configuration registers in which every stored bit lives in three flip-flops. The stored value of a bit is the majority of its three copies. When one copy disagrees with the other two, the bit repairs itself: at the next clock edge all three copies are rewritten with the majority value. No outside agent has to scrub the storage.

Each repair raises a one-cycle correction pulse. It also adds to an 8-bit upset counter that stops at its maximum value. A readout header takes the two low bits of that counter and three parity bits computed over the register contents. Software-facing access is a plain write port plus a combinational read port. A test-only injection port can invert chosen copies so that repair can be exercised.

Top module: `tmr_reg_bank`

## Requirements
- R1: While `rst_n` is low, every register reads 0, `seu_count` is 0, `corr_pulse` is 0, and both header outputs are 0.
- R2: A write with `wr_en` high and `wr_addr` below NUM_REGS (default 20) loads all three copies at the clock edge. From then on, `rd_data` for that address returns the written byte combinationally.
- R3: Inverting one copy of a bit (`inj_copy` 0, 1 or 2 selects the copy; 3 selects none) leaves the read value unchanged. At the following edge the copy is rewritten. A later inversion of a different copy of the same bit therefore still leaves the read value unchanged.
- R4: `corr_pulse` is high for exactly the one cycle after an edge at which at least one bit was repaired, and low otherwise.
- R5: At each repair edge, `seu_count` grows by the number of bits repaired at that edge. Each corrupted bit is counted once. The counter saturates at 255 and then holds.
- R6: `hdr_cnt_lsb` equals `seu_count[1:0]`. `hdr_parity[k]` is the XOR of every bit of every register whose index modulo 3 equals k, for k = 0, 1, 2.
- R7: A write to an address of NUM_REGS or above changes no register. A read of such an address returns 0.
- R8: A write to a register discards any pending repair of that register's bits. Those bits are neither counted nor pulsed. Injection into the register being written in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write register index |
| wr_data | input | 8 | Write byte |
| rd_addr | input | 5 | Read register index |
| rd_data | output | 8 | Majority-voted byte at `rd_addr` |
| inj_en | input | 1 | Test injection strobe |
| inj_reg | input | 5 | Register index to corrupt |
| inj_mask | input | 8 | Bits of that register to corrupt |
| inj_copy | input | 2 | Copy to invert (0..2, 3 = none) |
| corr_pulse | output | 1 | One-cycle repair indication |
| seu_count | output | 8 | Saturating count of repaired bits |
| hdr_cnt_lsb | output | 2 | Low counter bits for the header |
| hdr_parity | output | 3 | Register-group parity for the header |

## Verification
Assertions check on every cycle that:
- a repair never changes the voted value of a bit;
- a write leaves the three copies equal;
- the counter never goes down and stays put once it reaches its cap;
- every correction pulse comes with a counter step unless the counter is already at the cap;
- out-of-range reads return zero.

Only the bench scenarios can show the rest, checked against a behavioural model:
- the count added when several bits are repaired at one edge;
- the pending repair that a write discards;
- the parity values over groups of registers;
- the evidence of repair seen through a second injection into another copy.

// File: rtl/seu_bank_pkg.sv
`timescale 1ns/1ps
package seu_bank_pkg;
   localparam int unsigned COPIES  = 3;
   localparam int unsigned PAR_GRP = 3;
   localparam int unsigned HDR_LSB = 2;

   function automatic logic vote3(input logic [COPIES-1:0] c);
      return (c[0] & c[1]) | (c[0] & c[2]) | (c[1] & c[2]);
   endfunction

   function automatic logic [COPIES-1:0] copy_onehot(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3'b001;
         2'd1:    return 3'b010;
         2'd2:    return 3'b100;
         default: return 3'b000;
      endcase
   endfunction
endpackage

// File: rtl/tmr_bit.sv
`timescale 1ns/1ps
module tmr_bit
   import seu_bank_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bit,
   input  logic [COPIES-1:0] inj,
   output logic              q,
   output logic              fix
);
   logic [COPIES-1:0] cp;
   logic              disagree;

   assign q        = vote3(cp);
   assign disagree = !((cp[0] == cp[1]) && (cp[1] == cp[2]));
   assign fix      = disagree & ~wr_en & ~(|inj);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cp <= '0;
      else if (wr_en)    cp <= {COPIES{wr_bit}};
      else if (|inj)     cp <= cp ^ inj;
      else if (disagree) cp <= {COPIES{q}};
   end

   // R3: a repair rewrites copies without moving the voted value
   a_r3_vote_kept: assert property (@(posedge clk) disable iff (!rst_n)
      fix |=> (q == $past(q)));

   // R2: after a write the copies agree and hold the written bit
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!disagree && (q == $past(wr_bit))));
endmodule

// File: rtl/upset_counter.sv
`timescale 1ns/1ps
module upset_counter #(
   parameter int CNT_W    = 8,
   parameter int IN_W     = 160,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IN_W-1:0]  hits,
   output logic [CNT_W-1:0] count
);
   localparam int PC_W  = $clog2(IN_W + 1);
   localparam int SUM_W = CNT_W + PC_W;
   localparam logic [SUM_W-1:0] CAP = {{PC_W{1'b0}}, {CNT_W{1'b1}}};

   logic [PC_W-1:0]  pc;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      pc = '0;
      for (int i = 0; i < IN_W; i++) pc = pc + PC_W'(hits[i]);
      sum = {{PC_W{1'b0}}, count} + {{CNT_W{1'b0}}, pc};
   end

   generate
      if (SATURATE) begin : g_sat
         assign nxt = (sum > CAP) ? CAP[CNT_W-1:0] : sum[CNT_W-1:0];

         // R5: never decreases while running
         a_r5_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            count >= $past(count));
         // R5: once at the cap it stays there
         a_r5_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (count == CAP[CNT_W-1:0]) |=> (count == CAP[CNT_W-1:0]));
      end else begin : g_wrap
         assign nxt = sum[CNT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= nxt;
   end
endmodule

// File: rtl/tmr_reg_bank.sv
`timescale 1ns/1ps
module tmr_reg_bank
   import seu_bank_pkg::*;
#(
   parameter  int NUM_REGS = 20,
   parameter  int REG_W    = 8,
   parameter  int CNT_W    = 8,
   parameter  bit SATURATE = 1'b1,
   localparam int ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic              inj_en,
   input  logic [ADDR_W-1:0] inj_reg,
   input  logic [REG_W-1:0]  inj_mask,
   input  logic [1:0]        inj_copy,
   output logic              corr_pulse,
   output logic [CNT_W-1:0]  seu_count,
   output logic [1:0]        hdr_cnt_lsb,
   output logic [2:0]        hdr_parity
);
   localparam int NBITS = NUM_REGS * REG_W;

   if (NUM_REGS < PAR_GRP) begin : g_bad_regs
      $error("tmr_reg_bank: NUM_REGS must be at least 3");
   end
   if (REG_W < 1) begin : g_bad_width
      $error("tmr_reg_bank: REG_W must be positive");
   end
   if (CNT_W < HDR_LSB) begin : g_bad_cnt
      $error("tmr_reg_bank: CNT_W must be at least 2");
   end

   logic [NUM_REGS-1:0][REG_W-1:0] q_arr;
   logic [NBITS-1:0]               fix_all;
   logic [COPIES-1:0]              copy_hot;

   assign copy_hot = copy_onehot(inj_copy);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic wr_hit, inj_hit;
      assign wr_hit  = wr_en  && (wr_addr == ADDR_W'(r));
      assign inj_hit = inj_en && (inj_reg == ADDR_W'(r));
      for (genvar b = 0; b < REG_W; b++) begin : g_bit
         tmr_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_hit),
            .wr_bit (wr_data[b]),
            .inj    ((inj_hit && inj_mask[b]) ? copy_hot : 3'b000),
            .q      (q_arr[r][b]),
            .fix    (fix_all[r*REG_W + b])
         );
      end
   end

   upset_counter #(.CNT_W(CNT_W), .IN_W(NBITS), .SATURATE(SATURATE)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .hits  (fix_all),
      .count (seu_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) corr_pulse <= 1'b0;
      else        corr_pulse <= |fix_all;
   end

   always_comb begin
      rd_data = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (rd_addr == ADDR_W'(r)) rd_data = q_arr[r];
   end

   for (genvar k = 0; k < PAR_GRP; k++) begin : g_par
      always_comb begin
         hdr_parity[k] = 1'b0;
         for (int r = 0; r < NUM_REGS; r++)
            if ((r % PAR_GRP) == k) hdr_parity[k] = hdr_parity[k] ^ (^q_arr[r]);
      end
   end

   assign hdr_cnt_lsb = seu_count[1:0];

   // R4: a correction pulse always comes with a counter step below the cap
   a_r4_pulse_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (corr_pulse && ($past(seu_count) != {CNT_W{1'b1}})) |-> (seu_count != $past(seu_count)));

   // R7: addresses past the bank read as zero
   a_r7_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_addr) >= NUM_REGS) |-> (rd_data == '0));
endmodule

// File: tb/tb_tmr_reg_bank.sv
`timescale 1ns/1ps
module tb_tmr_reg_bank;
   localparam int NR = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [4:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       inj_en = 1'b0;
   logic [4:0] inj_reg = '0;
   logic [7:0] inj_mask = '0;
   logic [1:0] inj_copy = 2'd3;
   logic       corr_pulse;
   logic [7:0] seu_count;
   logic [1:0] hdr_cnt_lsb;
   logic [2:0] hdr_parity;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string tag = "R2";

   int mreg[NR];
   int mdirty[NR];
   int mcount = 0;
   int mpulse = 0;

   always #5 clk = ~clk;

   tmr_reg_bank dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .inj_en(inj_en), .inj_reg(inj_reg),
      .inj_mask(inj_mask), .inj_copy(inj_copy), .corr_pulse(corr_pulse),
      .seu_count(seu_count), .hdr_cnt_lsb(hdr_cnt_lsb), .hdr_parity(hdr_parity)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_parity(input int k);
      int p = 0;
      for (int r = 0; r < NR; r++) if (r % 3 == k) p ^= $countones(mreg[r]) & 1;
      return p;
   endfunction

   task automatic compare_all();
      int rexp;
      rexp = (int'(rd_addr) < NR) ? mreg[rd_addr] : 0;
      check((int'(rd_addr) < NR) ? tag : "R7 read", rd_data, rexp);
      check("R5 count", seu_count, mcount);
      check("R4 pulse", corr_pulse, mpulse);
      check("R6 lsb", hdr_cnt_lsb, mcount & 3);
      check("R6 parity", hdr_parity, (exp_parity(2) << 2) | (exp_parity(1) << 1) | exp_parity(0));
   endtask

   // drive inputs after a falling edge, update the model at the rising edge, compare at the next falling edge
   task automatic cyc(input bit we, input int wa, input int wd, input int ra,
                      input bit ie, input int ir, input int im, input int ic);
      int n;
      wr_en = we; wr_addr = 5'(wa); wr_data = 8'(wd); rd_addr = 5'(ra);
      inj_en = ie; inj_reg = 5'(ir); inj_mask = 8'(im); inj_copy = 2'(ic);
      @(posedge clk);
      n = 0;
      for (int r = 0; r < NR; r++) begin
         if (!(we && wa == r)) n += $countones(mdirty[r]);
         mdirty[r] = 0;
      end
      mcount = (mcount + n > 255) ? 255 : mcount + n;
      mpulse = (n > 0);
      if (we && wa < NR) mreg[wa] = wd & 255;
      if (ie && ir < NR && ic < 3 && !(we && wa == ir)) mdirty[ir] = im & 255;
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int ra);
      cyc(0, 0, 0, ra, 0, 0, 0, 3);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < NR; r++) begin mreg[r] = 0; mdirty[r] = 0; end
      // R1: outputs held at zero during reset
      repeat (3) @(negedge clk);
      check("R1 rd", rd_data, 0);
      check("R1 count", seu_count, 0);
      check("R1 pulse", corr_pulse, 0);
      check("R1 hdr", {hdr_cnt_lsb, hdr_parity}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: write every register, then sweep reads
      tag = "R2";
      for (int r = 0; r < NR; r++) cyc(1, r, (r * 37 + 5) & 255, r, 0, 0, 0, 3);
      for (int r = 0; r < NR; r++) idle(r);

      // R7: out-of-range write ignored, out-of-range read zero
      tag = "R7 no write";
      cyc(1, 25, 8'hAA, 25, 0, 0, 0, 3);
      cyc(1, 31, 8'h55, 31, 0, 0, 0, 3);
      for (int a = 20; a < 32; a++) idle(a);
      for (int r = 0; r < NR; r++) idle(r);

      // R3: single-copy upset is masked, repaired, then other copies can be hit
      tag = "R3";
      cyc(0, 0, 0, 3, 1, 3, 8'h10, 0);
      idle(3); idle(3);
      cyc(0, 0, 0, 3, 1, 3, 8'h10, 1);
      idle(3); idle(3);
      cyc(0, 0, 0, 3, 1, 3, 8'h10, 2);
      idle(3); idle(3);
      check("R3 value", rd_data, mreg[3]);
      // copy select 3 means no copy
      cyc(0, 0, 0, 4, 1, 4, 8'hFF, 3);
      idle(4);

      // R5: eight bits repaired on one edge add eight
      tag = "R5 multi";
      cyc(0, 0, 0, 7, 1, 7, 8'hFF, 2);
      idle(7); idle(7);

      // R8: a write discards a pending repair; injection into the written register is ignored
      tag = "R8";
      cyc(0, 0, 0, 9, 1, 9, 8'h0F, 1);
      cyc(1, 9, 8'h3C, 9, 0, 0, 0, 3);
      idle(9);
      cyc(1, 10, 8'hC3, 10, 1, 10, 8'hFF, 0);
      idle(10); idle(10);

      // R5: drive the counter to saturation and beyond
      tag = "R5 sat";
      for (int i = 0; i < 36; i++) begin
         cyc(0, 0, 0, i % NR, 1, i % NR, 8'hFF, i % 3);
         idle(i % NR);
      end
      check("R5 saturated", seu_count, 255);
      for (int r = 0; r < NR; r++) idle(r);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule